// File: doc/BRIEF.md
# Frame-Delay Sample Comparator

This block takes in a stream of signed two's complement converter samples, each qualified by a valid strobe. It keeps the most recent full frame of `FRAME_LEN` samples in a circular store. Each accepted sample is compared with the sample that held the same position in the store one frame earlier, and the block reports the absolute difference between the two. When the input is sampled coherently and no bit errors occur, every sample repeats exactly one frame later, so the reported magnitude is zero. A non-zero magnitude points to a corrupted word, and its size shows the weight of the bit that flipped. A downstream counter compares the magnitude against thresholds to sort the errors.

After reset the store first fills with one complete frame. No comparison is made during this phase. The block arms when the last sample of the first frame is written, and it stays armed until the next reset. For every later sample, the old entry at the write position is read out and the new sample replaces it in the same cycle. The magnitude appears on a registered output one cycle after the sample is accepted, together with a matching valid flag. To exercise every output code, `FRAME_LEN` should be at least 2 to the power of the converter resolution.

Top module: `frame_delay_cmp`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `valid_o` is 0, `armed_o` is 0 and `diff_o` is 0.
- R2: During the fill phase, which covers the first `FRAME_LEN` valid samples after reset, `valid_o` stays 0. `valid_o` is never 1 while `armed_o` is 0.
- R3: `armed_o` rises at the clock edge that accepts the `FRAME_LEN`-th valid sample after reset. It stays 1 until reset.
- R4: Each valid sample k that is accepted while armed sets `valid_o` to 1 one cycle later, with `diff_o` = |x[k] - x[k-FRAME_LEN]|. Here the index counts valid samples only, and `diff_o` is an unsigned 17-bit magnitude.
- R5: A cycle with `valid_i` low advances no position and stores nothing. `valid_o` is 0 in the following cycle, and `diff_o` holds its previous value.
- R6: Within one cycle, the comparison uses the entry stored before the write, and the new sample replaces that entry. The next frame is therefore compared against the new sample.
- R7: The magnitude never overflows. An input of -32768 compared against a stored 32767, or the reverse, gives 65535. `diff_o` never exceeds 65535.
- R8: If a frame repeats the previous frame exactly, every output of that frame is 0.
- R9: A reset in the middle of operation clears `armed_o` and restarts the fill phase from position 0. After the reset, no valid output appears until a full new frame has been captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 16 | Signed two's complement sample |
| valid_i | input | 1 | Sample strobe |
| diff_o | output | 17 | Absolute difference with the same-index sample of the previous frame |
| valid_o | output | 1 | `diff_o` carries a new result |
| armed_o | output | 1 | First frame captured, comparisons active |

## Verification
The bench aims at the frame boundary. A design that arms one sample early or late would raise `valid_o` on the last fill sample, or miss the first compare of frame two. It would also shift every later pairing by one position. Gaps in the valid strobe are placed mid-frame: a design that advances its pointer on idle cycles compares against the wrong index, and one that updates the output during gaps shows a changing `diff_o`. Full-scale opposite values detect a difference taken at 16 bits, which wraps to a small or negative magnitude. Corrupted samples followed by a clean frame detect a write-after-read ordering fault, because the next frame must differ against the corrupted value. A reset in the middle of operation detects an armed flag or a fill count that survives reset.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  typedef enum logic {
    ST_FILL = 1'b0,
    ST_RUN  = 1'b1
  } fdc_state_e;
endpackage

// File: rtl/fdc_frame_store.sv
module fdc_frame_store #(
  parameter int SAMPLE_W  = 16,
  parameter int FRAME_LEN = 1024,
  localparam int ADDR_W   = $clog2(FRAME_LEN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [SAMPLE_W-1:0] wr_data_i,
  output logic [SAMPLE_W-1:0] rd_data_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_LEN - 1);

  logic [SAMPLE_W-1:0] mem_q [FRAME_LEN];
  logic [ADDR_W-1:0]   ptr_q;

  // old contents at the write address are visible before the write lands
  assign rd_data_o = mem_q[ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (wr_en_i) begin
      ptr_q <= (ptr_q == LAST_ADDR) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[ptr_q] <= wr_data_i;
  end
endmodule

// File: rtl/fdc_arm_ctrl.sv
module fdc_arm_ctrl
  import fdc_pkg::*;
#(
  parameter int FRAME_LEN = 1024,
  localparam int ADDR_W   = $clog2(FRAME_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic armed_o
);
  localparam logic [ADDR_W-1:0] LAST_CNT = ADDR_W'(FRAME_LEN - 1);

  fdc_state_e        state_q;
  logic [ADDR_W-1:0] fill_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_FILL;
      fill_cnt_q <= '0;
    end else if (valid_i && state_q == ST_FILL) begin
      if (fill_cnt_q == LAST_CNT) begin
        state_q <= ST_RUN;
      end else begin
        fill_cnt_q <= fill_cnt_q + 1'b1;
      end
    end
  end

  assign armed_o = (state_q == ST_RUN);
endmodule

// File: rtl/fdc_absdiff.sv
module fdc_absdiff #(
  parameter int SAMPLE_W = 16,
  localparam int DIFF_W  = SAMPLE_W + 1
) (
  input  logic [SAMPLE_W-1:0] cur_i,
  input  logic [SAMPLE_W-1:0] old_i,
  output logic [DIFF_W-1:0]   mag_o
);
  logic signed [DIFF_W-1:0] cur_ext, old_ext, delta;

  always_comb begin
    cur_ext = signed'({cur_i[SAMPLE_W-1], cur_i});
    old_ext = signed'({old_i[SAMPLE_W-1], old_i});
    delta   = cur_ext - old_ext;
    mag_o   = delta[DIFF_W-1] ? DIFF_W'(-delta) : DIFF_W'(delta);
  end
endmodule

// File: rtl/frame_delay_cmp.sv
module frame_delay_cmp #(
  parameter int SAMPLE_W  = 16,
  parameter int FRAME_LEN = 1024,
  localparam int DIFF_W   = SAMPLE_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                valid_i,
  output logic [DIFF_W-1:0]   diff_o,
  output logic                valid_o,
  output logic                armed_o
);
  logic [SAMPLE_W-1:0] old_sample;
  logic [DIFF_W-1:0]   mag;
  logic                armed;
  logic [DIFF_W-1:0]   diff_q;
  logic                valid_q;

  fdc_frame_store #(.SAMPLE_W(SAMPLE_W), .FRAME_LEN(FRAME_LEN)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (valid_i),
    .wr_data_i (sample_i),
    .rd_data_o (old_sample)
  );

  fdc_arm_ctrl #(.FRAME_LEN(FRAME_LEN)) u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .armed_o (armed)
  );

  fdc_absdiff #(.SAMPLE_W(SAMPLE_W)) u_diff (
    .cur_i (sample_i),
    .old_i (old_sample),
    .mag_o (mag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diff_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i && armed;
      if (valid_i && armed) diff_q <= mag;
    end
  end

  assign diff_o  = diff_q;
  assign valid_o = valid_q;
  assign armed_o = armed;
endmodule

// File: rtl/fdc_checker.sv
module fdc_checker #(
  parameter int SAMPLE_W = 16,
  localparam int DIFF_W  = SAMPLE_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DIFF_W-1:0] diff_o,
  input logic              valid_o,
  input logic              armed_o
);
  // R2
  valid_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> armed_o);

  // R3
  arm_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |=> armed_o);

  // R4
  armed_sample_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && armed_o) |=> valid_o);

  // R5
  idle_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(diff_o));

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_o <= DIFF_W'((1 << SAMPLE_W) - 1));
endmodule

bind frame_delay_cmp fdc_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .diff_o  (diff_o),
  .valid_o (valid_o),
  .armed_o (armed_o)
);

// File: tb/frame_delay_cmp_tb.sv
module frame_delay_cmp_tb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] sample_i = '0;
  logic        valid_i = 1'b0;
  logic [16:0] diff_o;
  logic        valid_o, armed_o;

  int checks = 0, errors = 0;
  int ref_mem [N];
  int ref_ptr = 0, ref_cnt = 0;
  bit ref_armed = 0, exp_valid = 0;
  int exp_diff = 0;

  always #10 clk = ~clk;

  frame_delay_cmp #(.SAMPLE_W(16), .FRAME_LEN(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .valid_i(valid_i),
    .diff_o(diff_o), .valid_o(valid_o), .armed_o(armed_o)
  );

  task automatic check(input string tag);
    checks++;
    if (valid_o !== exp_valid || armed_o !== ref_armed || int'(diff_o) !== exp_diff) begin
      errors++;
      $display("FAIL %s: valid=%0b armed=%0b diff=%0d expected valid=%0b armed=%0b diff=%0d",
               tag, valid_o, armed_o, diff_o, exp_valid, ref_armed, exp_diff);
    end
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_ni = 1'b0; valid_i = 1'b0;
    ref_ptr = 0; ref_cnt = 0; ref_armed = 0; exp_valid = 0; exp_diff = 0;
    @(negedge clk);
    check(tag);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic step(input bit v, input int s, input string tag);
    @(negedge clk);
    valid_i = v; sample_i = 16'(s);
    if (v) begin
      exp_valid = ref_armed;
      if (ref_armed) exp_diff = (s >= ref_mem[ref_ptr]) ? s - ref_mem[ref_ptr] : ref_mem[ref_ptr] - s;
      ref_mem[ref_ptr] = s;
      ref_ptr = (ref_ptr + 1) % N;
      if (!ref_armed) begin
        ref_cnt++;
        if (ref_cnt == N) ref_armed = 1;
      end
    end else begin
      exp_valid = 0;
    end
    @(posedge clk); #1;
    check(tag);
  endtask

  function automatic int base(input int i);
    return (i * 2731) % 4096 - 2048;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset("R1 reset state");
    // fill phase
    for (int i = 0; i < N; i++) step(1, base(i), i == N-1 ? "R3 arm edge" : "R2 fill silent");
    // identical frame
    for (int i = 0; i < N; i++) step(1, base(i), "R8 repeat frame zero");
    // corrupted samples and gaps
    for (int i = 0; i < N; i++) begin
      step(1, (i % 5 == 2) ? base(i) + (1 << (i % 12)) : base(i), "R4 corrupted diff");
      if (i % 4 == 1) begin
        step(0, 12345, "R5 idle gap");
        step(0, -777, "R5 idle gap");
      end
    end
    // clean frame compares against corrupted values stored last frame
    for (int i = 0; i < N; i++) step(1, base(i), "R6 read before write");
    // extremes
    for (int i = 0; i < N; i++) step(1, (i % 2) ? 32767 : -32768, "R7 extreme");
    for (int i = 0; i < N; i++) step(1, (i % 2) ? -32768 : 32767, "R7 extreme swap");
    // mid-frame reset
    for (int i = 0; i < 5; i++) step(1, i * 100, "R4 partial frame");
    do_reset("R9 reset mid run");
    for (int i = 0; i < N; i++) step(1, 3 * i - 20, "R9 refill silent");
    for (int i = 0; i < N; i++) step(1, 3 * i - 20 + (i == 7 ? -64 : 0), "R9 compare after refill");
    step(0, 0, "R5 final idle");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule